// File: doc/BRIEF.md
# Shadow-Gated Result Latch Unit

This block holds the finished results of several functional units in a scoreboard-style out-of-order core that does not rename registers. Each functional unit owns one latch. When a unit completes, it loads its result word, the architectural destination register number, an age tag and a set of shadow owners into its latch. From the next cycle the value can be read by waiting consumers through the forwarding ports, even though it has not yet reached the register file.

The register-file write is held back while any shadow owner in the latch's set is still unresolved. Such an owner is an older operation that may still fault or be mis-speculated, for example the memory half of a load with address update that shadows the address half. Owners resolve through a release vector, which clears their bits, or through a cancel vector, which throws away every latch they shadow. Latches that are free of shadows compete for a parameterised number of write ports, oldest first. A younger latch never writes a register that an older busy latch still targets. A granted latch raises a finish pulse and becomes free on the next cycle.

Top module: `shadow_result_latch`

## Requirements
- R1: After reset every latch is free: `busy`, `wr_en`, `finish` and `fwd_hit` are all zero.
- R2: A capture request to a free latch makes it busy from the next cycle, holding the given register, data and age. A capture request to a busy latch is ignored, and the latch keeps its earlier contents.
- R3: A forwarding port reports `fwd_hit`=1 and the held data when the latch named by `fwd_tag` is busy and holds `fwd_reg`, whatever its shadow state. Otherwise it reports `fwd_hit`=0 and `fwd_data`=0.
- R4: A busy latch whose shadow set is not empty never drives a write port and never raises `finish`.
- R5: A set bit k of `shd_release` removes owner k from every latch's shadow set at the clock edge. This includes a latch being captured in that cycle. A latch whose set becomes empty may be granted a write in the following cycle.
- R6: A set bit k of `shd_cancel` frees, at the next edge and without any write, every busy latch whose set contains k. A capture whose set contains k is dropped in the same way. Cancel bits outside a latch's set do not affect it. Cancel takes precedence over a release of the same bit.
- R7: Eligible latches are granted in age order. Write port 0 takes the oldest, port 1 the next oldest, and so on. A smaller age value is older, and equal ages are ordered by lower latch index.
- R8: A latch is not eligible while an older busy latch targets the same register, so no two write ports name the same register in one cycle.
- R9: In the cycle a latch drives a write port, its bit of `finish` is 1. The latch is free from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_valid | input | N_LATCH | Capture request, one bit per latch |
| cap_reg | input | N_LATCH x REG_W | Destination register for each capture |
| cap_data | input | N_LATCH x DATA_W | Result word for each capture |
| cap_shadow | input | N_LATCH x N_SHADOW | Shadow owner set for each capture |
| cap_age | input | N_LATCH x AGE_W | Age tag for each capture, smaller is older |
| shd_release | input | N_SHADOW | Owners that resolved without fault |
| shd_cancel | input | N_SHADOW | Owners that were cancelled |
| fwd_tag | input | N_FWD_PORT x TAG_W | Producer latch named by each forwarding read |
| fwd_reg | input | N_FWD_PORT x REG_W | Register each forwarding read expects |
| fwd_hit | output | N_FWD_PORT | Forwarding read found a matching busy latch |
| fwd_data | output | N_FWD_PORT x DATA_W | Forwarded value, zero on a miss |
| wr_en | output | N_WR_PORT | Register-file write strobe per port |
| wr_reg | output | N_WR_PORT x REG_W | Register written by each port |
| wr_data | output | N_WR_PORT x DATA_W | Data written by each port |
| finish | output | N_LATCH | One-cycle finish pulse per latch, same cycle as its write |
| busy | output | N_LATCH | Latch holds a result |

## Verification
A shadow mask that keeps a stale bit shows up as a write that never comes: the bench expects the write strobe in the first cycle after the release edge and sees nothing. A mask that loses a bit shows up as a write one or more cycles early. A corrupted age or register field in a latch shows up in the cycle the grants are decided, as a swapped write-port order or as two latches committing the same register back to back in the wrong order. A valid bit that fails to clear after a grant or a cancel shows up one cycle later as a lingering `busy`, a repeated write, or a forwarding hit that should have missed.

// File: rtl/srl_pkg.sv
package srl_pkg;

   // Total age order: smaller age is older, equal ages fall back to lower index.
   function automatic logic is_older(input int unsigned a_age, input int a_idx,
                                     input int unsigned b_age, input int b_idx);
      return (a_age < b_age) || ((a_age == b_age) && (a_idx < b_idx));
   endfunction

endpackage

// File: rtl/srl_entry.sv
module srl_entry #(
   parameter int REG_W    = 5,
   parameter int DATA_W   = 32,
   parameter int N_SHADOW = 4,
   parameter int AGE_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap_valid,
   input  logic [REG_W-1:0]    cap_reg,
   input  logic [DATA_W-1:0]   cap_data,
   input  logic [N_SHADOW-1:0] cap_shadow,
   input  logic [AGE_W-1:0]    cap_age,
   input  logic [N_SHADOW-1:0] shd_release,
   input  logic [N_SHADOW-1:0] shd_cancel,
   input  logic                grant,
   output logic                valid,
   output logic [N_SHADOW-1:0] mask,
   output logic [REG_W-1:0]    dst_reg,
   output logic [DATA_W-1:0]   data,
   output logic [AGE_W-1:0]    age
);

   logic held_killed;
   logic cap_killed;
   logic take;

   assign held_killed = |(mask & shd_cancel);
   assign cap_killed  = |(cap_shadow & shd_cancel);
   assign take        = !valid && cap_valid && !cap_killed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid   <= 1'b0;
         mask    <= '0;
         dst_reg <= '0;
         data    <= '0;
         age     <= '0;
      end else if (valid) begin
         if (held_killed || grant) begin
            valid <= 1'b0;
            mask  <= '0;
         end else begin
            mask <= mask & ~shd_release;
         end
      end else if (take) begin
         valid   <= 1'b1;
         mask    <= cap_shadow & ~shd_release;
         dst_reg <= cap_reg;
         data    <= cap_data;
         age     <= cap_age;
      end
   end

endmodule

// File: rtl/srl_arbiter.sv
module srl_arbiter #(
   parameter int N_LATCH   = 4,
   parameter int N_SHADOW  = 4,
   parameter int REG_W     = 5,
   parameter int DATA_W    = 32,
   parameter int AGE_W     = 4,
   parameter int N_WR_PORT = 2
) (
   input  logic [N_LATCH-1:0]               valid,
   input  logic [N_LATCH-1:0][N_SHADOW-1:0] mask,
   input  logic [N_LATCH-1:0][REG_W-1:0]    dst_reg,
   input  logic [N_LATCH-1:0][DATA_W-1:0]   data,
   input  logic [N_LATCH-1:0][AGE_W-1:0]    age,
   output logic [N_LATCH-1:0]               grant,
   output logic [N_WR_PORT-1:0]             wr_en,
   output logic [N_WR_PORT-1:0][REG_W-1:0]  wr_reg,
   output logic [N_WR_PORT-1:0][DATA_W-1:0] wr_data
);
   import srl_pkg::*;

   logic [N_LATCH-1:0] blocked;
   logic [N_LATCH-1:0] eligible;

   // A latch waits while an older busy latch holds the same destination.
   always_comb begin
      blocked = '0;
      for (int i = 0; i < N_LATCH; i++) begin
         for (int j = 0; j < N_LATCH; j++) begin
            if (j != i && valid[j] && (dst_reg[j] == dst_reg[i]) &&
                is_older(int'(unsigned'(age[j])), j, int'(unsigned'(age[i])), i))
               blocked[i] = 1'b1;
         end
      end
   end

   always_comb begin
      for (int i = 0; i < N_LATCH; i++)
         eligible[i] = valid[i] && (mask[i] == '0) && !blocked[i];
   end

   // Ports pick in turn, each taking the oldest latch not yet granted.
   always_comb begin
      logic [N_LATCH-1:0] taken;
      taken   = '0;
      wr_en   = '0;
      wr_reg  = '0;
      wr_data = '0;
      for (int p = 0; p < N_WR_PORT; p++) begin
         logic found;
         int   best;
         found = 1'b0;
         best  = 0;
         for (int i = 0; i < N_LATCH; i++) begin
            if (eligible[i] && !taken[i]) begin
               if (!found || is_older(int'(unsigned'(age[i])), i,
                                      int'(unsigned'(age[best])), best)) begin
                  found = 1'b1;
                  best  = i;
               end
            end
         end
         if (found) begin
            taken[best] = 1'b1;
            wr_en[p]    = 1'b1;
            wr_reg[p]   = dst_reg[best];
            wr_data[p]  = data[best];
         end
      end
      grant = taken;
   end

endmodule

// File: rtl/srl_fwd.sv
module srl_fwd #(
   parameter int N_LATCH    = 4,
   parameter int REG_W      = 5,
   parameter int DATA_W     = 32,
   parameter int N_FWD_PORT = 2,
   localparam int TAG_W     = $clog2(N_LATCH)
) (
   input  logic [N_LATCH-1:0]                valid,
   input  logic [N_LATCH-1:0][REG_W-1:0]     dst_reg,
   input  logic [N_LATCH-1:0][DATA_W-1:0]    data,
   input  logic [N_FWD_PORT-1:0][TAG_W-1:0]  fwd_tag,
   input  logic [N_FWD_PORT-1:0][REG_W-1:0]  fwd_reg,
   output logic [N_FWD_PORT-1:0]             fwd_hit,
   output logic [N_FWD_PORT-1:0][DATA_W-1:0] fwd_data
);

   for (genvar k = 0; k < N_FWD_PORT; k++) begin : g_port
      logic in_range;
      logic match;
      if ((1 << TAG_W) == N_LATCH) begin : g_pow2
         assign in_range = 1'b1;
      end else begin : g_npow2
         assign in_range = (int'(unsigned'(fwd_tag[k])) < N_LATCH);
      end
      assign match = in_range && valid[fwd_tag[k]] &&
                     (dst_reg[fwd_tag[k]] == fwd_reg[k]);
      assign fwd_hit[k]  = match;
      assign fwd_data[k] = match ? data[fwd_tag[k]] : '0;
   end

endmodule

// File: rtl/shadow_result_latch.sv
module shadow_result_latch #(
   parameter int N_LATCH    = 4,
   parameter int N_ARCH_REG = 32,
   parameter int DATA_W     = 32,
   parameter int N_SHADOW   = 4,
   parameter int AGE_W      = 4,
   parameter int N_WR_PORT  = 2,
   parameter int N_FWD_PORT = 2,
   localparam int REG_W     = $clog2(N_ARCH_REG),
   localparam int TAG_W     = $clog2(N_LATCH)
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [N_LATCH-1:0]                    cap_valid,
   input  logic [N_LATCH-1:0][REG_W-1:0]         cap_reg,
   input  logic [N_LATCH-1:0][DATA_W-1:0]        cap_data,
   input  logic [N_LATCH-1:0][N_SHADOW-1:0]      cap_shadow,
   input  logic [N_LATCH-1:0][AGE_W-1:0]         cap_age,
   input  logic [N_SHADOW-1:0]                   shd_release,
   input  logic [N_SHADOW-1:0]                   shd_cancel,
   input  logic [N_FWD_PORT-1:0][TAG_W-1:0]      fwd_tag,
   input  logic [N_FWD_PORT-1:0][REG_W-1:0]      fwd_reg,
   output logic [N_FWD_PORT-1:0]                 fwd_hit,
   output logic [N_FWD_PORT-1:0][DATA_W-1:0]     fwd_data,
   output logic [N_WR_PORT-1:0]                  wr_en,
   output logic [N_WR_PORT-1:0][REG_W-1:0]       wr_reg,
   output logic [N_WR_PORT-1:0][DATA_W-1:0]      wr_data,
   output logic [N_LATCH-1:0]                    finish,
   output logic [N_LATCH-1:0]                    busy
);

   if (N_LATCH < 2)                           $error("N_LATCH must be at least 2");
   if (N_ARCH_REG < 2)                        $error("N_ARCH_REG must be at least 2");
   if (N_SHADOW < 1)                          $error("N_SHADOW must be at least 1");
   if (N_WR_PORT < 1 || N_WR_PORT > N_LATCH)  $error("N_WR_PORT out of range");
   if (N_FWD_PORT < 1)                        $error("N_FWD_PORT must be at least 1");
   if (AGE_W < 1 || AGE_W > 31)               $error("AGE_W out of range");

   logic [N_LATCH-1:0]               ent_valid;
   logic [N_LATCH-1:0][N_SHADOW-1:0] ent_mask;
   logic [N_LATCH-1:0][REG_W-1:0]    ent_reg;
   logic [N_LATCH-1:0][DATA_W-1:0]   ent_data;
   logic [N_LATCH-1:0][AGE_W-1:0]    ent_age;
   logic [N_LATCH-1:0]               ent_grant;

   for (genvar i = 0; i < N_LATCH; i++) begin : g_entry
      srl_entry #(
         .REG_W   (REG_W),
         .DATA_W  (DATA_W),
         .N_SHADOW(N_SHADOW),
         .AGE_W   (AGE_W)
      ) u_entry (
         .clk        (clk),
         .rst_n      (rst_n),
         .cap_valid  (cap_valid[i]),
         .cap_reg    (cap_reg[i]),
         .cap_data   (cap_data[i]),
         .cap_shadow (cap_shadow[i]),
         .cap_age    (cap_age[i]),
         .shd_release(shd_release),
         .shd_cancel (shd_cancel),
         .grant      (ent_grant[i]),
         .valid      (ent_valid[i]),
         .mask       (ent_mask[i]),
         .dst_reg    (ent_reg[i]),
         .data       (ent_data[i]),
         .age        (ent_age[i])
      );
   end

   srl_arbiter #(
      .N_LATCH  (N_LATCH),
      .N_SHADOW (N_SHADOW),
      .REG_W    (REG_W),
      .DATA_W   (DATA_W),
      .AGE_W    (AGE_W),
      .N_WR_PORT(N_WR_PORT)
   ) u_arb (
      .valid  (ent_valid),
      .mask   (ent_mask),
      .dst_reg(ent_reg),
      .data   (ent_data),
      .age    (ent_age),
      .grant  (ent_grant),
      .wr_en  (wr_en),
      .wr_reg (wr_reg),
      .wr_data(wr_data)
   );

   srl_fwd #(
      .N_LATCH   (N_LATCH),
      .REG_W     (REG_W),
      .DATA_W    (DATA_W),
      .N_FWD_PORT(N_FWD_PORT)
   ) u_fwd (
      .valid   (ent_valid),
      .dst_reg (ent_reg),
      .data    (ent_data),
      .fwd_tag (fwd_tag),
      .fwd_reg (fwd_reg),
      .fwd_hit (fwd_hit),
      .fwd_data(fwd_data)
   );

   assign finish = ent_grant;
   assign busy   = ent_valid;

endmodule

// File: rtl/shadow_result_latch_chk.sv
module shadow_result_latch_chk #(
   parameter int N_LATCH    = 4,
   parameter int N_SHADOW   = 4,
   parameter int N_WR_PORT  = 2,
   parameter int N_FWD_PORT = 2,
   parameter int REG_W      = 5,
   parameter int TAG_W      = 2
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic [N_SHADOW-1:0]                shd_cancel,
   input logic [N_WR_PORT-1:0]               wr_en,
   input logic [N_WR_PORT-1:0][REG_W-1:0]    wr_reg,
   input logic [N_LATCH-1:0]                 finish,
   input logic [N_LATCH-1:0]                 busy,
   input logic [N_LATCH-1:0][N_SHADOW-1:0]   ent_mask,
   input logic [N_FWD_PORT-1:0][TAG_W-1:0]   fwd_tag,
   input logic [N_FWD_PORT-1:0]              fwd_hit
);

   p_finish_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(finish) == $countones(wr_en));

   for (genvar p = 0; p < N_WR_PORT; p++) begin : g_pa
      for (genvar q = p + 1; q < N_WR_PORT; q++) begin : g_pb
         p_one_write_per_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en[p] && wr_en[q]) |-> (wr_reg[p] != wr_reg[q]));
      end
   end

   for (genvar i = 0; i < N_LATCH; i++) begin : g_lat
      p_shadow_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (busy[i] && (ent_mask[i] != '0)) |-> !finish[i]);
      p_finish_needs_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
         finish[i] |-> busy[i]);
      p_grant_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
         finish[i] |=> !busy[i]);
      p_cancel_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (busy[i] && ((ent_mask[i] & shd_cancel) != '0)) |=> !busy[i]);
   end

   for (genvar k = 0; k < N_FWD_PORT; k++) begin : g_fw
      p_fwd_from_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
         fwd_hit[k] |-> ((int'(unsigned'(fwd_tag[k])) < N_LATCH) && busy[fwd_tag[k]]));
   end

endmodule

bind shadow_result_latch shadow_result_latch_chk #(
   .N_LATCH   (N_LATCH),
   .N_SHADOW  (N_SHADOW),
   .N_WR_PORT (N_WR_PORT),
   .N_FWD_PORT(N_FWD_PORT),
   .REG_W     (REG_W),
   .TAG_W     (TAG_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .shd_cancel(shd_cancel),
   .wr_en     (wr_en),
   .wr_reg    (wr_reg),
   .finish    (finish),
   .busy      (busy),
   .ent_mask  (ent_mask),
   .fwd_tag   (fwd_tag),
   .fwd_hit   (fwd_hit)
);

// File: tb/shadow_result_latch_tb_top.sv
module shadow_result_latch_tb_top;

   localparam int NL = 4;
   localparam int RW = 5;
   localparam int DW = 32;
   localparam int NS = 4;
   localparam int AW = 4;
   localparam int NP = 2;
   localparam int NF = 2;
   localparam int TW = 2;
   localparam int VW = TW + RW + DW + NS + AW;
   localparam int NVEC = 8;

   // vector: {latch, reg, data, shadow set, age}
   localparam logic [VW-1:0] VECS [NVEC] = '{
      {2'd0, 5'd1,  32'h0000_1111, 4'b0001, 4'd0},
      {2'd1, 5'd2,  32'hDEAD_BEEF, 4'b0000, 4'd3},
      {2'd2, 5'd31, 32'h1234_5678, 4'b0110, 4'd7},
      {2'd3, 5'd0,  32'hFFFF_FFFF, 4'b1000, 4'd15},
      {2'd0, 5'd17, 32'h0000_0000, 4'b1111, 4'd2},
      {2'd1, 5'd9,  32'hA5A5_5A5A, 4'b0100, 4'd9},
      {2'd2, 5'd4,  32'h8000_0001, 4'b0000, 4'd1},
      {2'd3, 5'd12, 32'h0F0F_F0F0, 4'b0011, 4'd5}
   };

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic [NL-1:0]          cap_valid = '0;
   logic [NL-1:0][RW-1:0]  cap_reg = '0;
   logic [NL-1:0][DW-1:0]  cap_data = '0;
   logic [NL-1:0][NS-1:0]  cap_shadow = '0;
   logic [NL-1:0][AW-1:0]  cap_age = '0;
   logic [NS-1:0]          shd_release = '0;
   logic [NS-1:0]          shd_cancel = '0;
   logic [NF-1:0][TW-1:0]  fwd_tag = '0;
   logic [NF-1:0][RW-1:0]  fwd_reg = '0;
   logic [NF-1:0]          fwd_hit;
   logic [NF-1:0][DW-1:0]  fwd_data;
   logic [NP-1:0]          wr_en;
   logic [NP-1:0][RW-1:0]  wr_reg;
   logic [NP-1:0][DW-1:0]  wr_data;
   logic [NL-1:0]          finish;
   logic [NL-1:0]          busy;

   int n_checks = 0;
   int n_fail = 0;
   logic done = 1'b0;

   always #5 clk = ~clk;

   shadow_result_latch #(
      .N_LATCH(NL), .N_ARCH_REG(32), .DATA_W(DW), .N_SHADOW(NS),
      .AGE_W(AW), .N_WR_PORT(NP), .N_FWD_PORT(NF)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_reg(cap_reg),
      .cap_data(cap_data), .cap_shadow(cap_shadow), .cap_age(cap_age),
      .shd_release(shd_release), .shd_cancel(shd_cancel),
      .fwd_tag(fwd_tag), .fwd_reg(fwd_reg), .fwd_hit(fwd_hit), .fwd_data(fwd_data),
      .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data),
      .finish(finish), .busy(busy)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Cross one clock edge, drop the one-shot inputs, settle at the falling edge.
   task automatic tick();
      @(posedge clk);
      #1;
      cap_valid   = '0;
      shd_release = '0;
      shd_cancel  = '0;
      @(negedge clk);
      #1;
   endtask

   task automatic load(input int l, input logic [RW-1:0] r, input logic [DW-1:0] d,
                       input logic [NS-1:0] s, input logic [AW-1:0] a);
      cap_valid[l]  = 1'b1;
      cap_reg[l]    = r;
      cap_data[l]   = d;
      cap_shadow[l] = s;
      cap_age[l]    = a;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      check("R1 busy", 64'(busy), 64'h0);
      check("R1 wr_en", 64'(wr_en), 64'h0);
      check("R1 finish", 64'(finish), 64'h0);
      check("R1 fwd_hit", 64'(fwd_hit), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;

      // Table walk: capture, forward, hold under shadow, release, commit.
      for (int v = 0; v < NVEC; v++) begin
         logic [TW-1:0] l;
         logic [RW-1:0] r;
         logic [DW-1:0] d;
         logic [NS-1:0] s;
         logic [AW-1:0] a;
         {l, r, d, s, a} = VECS[v];
         load(int'(l), r, d, s, a);
         tick();
         check("R2 busy after capture", 64'(busy), 64'(4'b0001 << l));
         fwd_tag[1] = l;
         fwd_reg[1] = r;
         #1;
         check("R3 fwd hit", 64'(fwd_hit[1]), 64'h1);
         check("R3 fwd data", 64'(fwd_data[1]), 64'(d));
         if (s != '0) begin
            check("R4 shadowed no write", 64'(wr_en), 64'h0);
            check("R4 shadowed no finish", 64'(finish), 64'h0);
            shd_release = s;
            tick();
         end
         check("R5 write after release", 64'(wr_en), 64'h1);
         check("R5 write reg", 64'(wr_reg[0]), 64'(r));
         check("R5 write data", 64'(wr_data[0]), 64'(d));
         check("R9 finish pulse", 64'(finish), 64'(4'b0001 << l));
         tick();
         check("R9 freed after grant", 64'(busy), 64'h0);
         check("R9 no repeat write", 64'(wr_en), 64'h0);
      end

      // R2 capture into a busy latch is ignored
      load(0, 5'd3, 32'hAAAA_0001, 4'b0001, 4'd1);
      tick();
      load(0, 5'd4, 32'hBBBB_0002, 4'b0000, 4'd2);
      tick();
      fwd_tag[0] = 2'd0; fwd_reg[0] = 5'd3;
      fwd_tag[1] = 2'd0; fwd_reg[1] = 5'd4;
      #1;
      check("R2 busy latch keeps data", 64'(fwd_data[0]), 64'hAAAA_0001);
      check("R3 fwd miss on reg mismatch", 64'(fwd_hit[1]), 64'h0);
      check("R3 fwd miss data zero", 64'(fwd_data[1]), 64'h0);
      fwd_tag[1] = 2'd2; fwd_reg[1] = 5'd3;
      #1;
      check("R3 fwd miss on idle latch", 64'(fwd_hit[1]), 64'h0);
      shd_release = 4'b0001;
      tick();
      check("R2 old contents written", 64'(wr_data[0]), 64'hAAAA_0001);
      check("R2 old reg written", 64'(wr_reg[0]), 64'd3);
      tick();

      // R6 cancel: foreign bit no effect, own bit frees without write
      load(1, 5'd6, 32'hC0C0_C0C0, 4'b0010, 4'd4);
      tick();
      shd_cancel = 4'b0100;
      tick();
      check("R6 foreign cancel keeps latch", 64'(busy), 64'h2);
      shd_cancel  = 4'b0010;
      shd_release = 4'b0010;
      tick();
      check("R6 cancel frees latch", 64'(busy), 64'h0);
      check("R6 cancel gives no write", 64'(wr_en), 64'h0);
      check("R6 cancel gives no finish", 64'(finish), 64'h0);
      load(3, 5'd8, 32'h1, 4'b1000, 4'd0);
      shd_cancel = 4'b1000;
      tick();
      check("R6 capture dropped by cancel", 64'(busy), 64'h0);

      // R5 release in the capture cycle
      load(2, 5'd10, 32'h2222_3333, 4'b0100, 4'd3);
      shd_release = 4'b0100;
      tick();
      check("R5 release at capture", 64'(wr_en), 64'h1);
      check("R5 release at capture data", 64'(wr_data[0]), 64'h2222_3333);
      tick();

      // R7 age order across ports
      load(2, 5'd7,  32'h0000_0072, 4'b0000, 4'd5);
      load(3, 5'd9,  32'h0000_0093, 4'b0000, 4'd2);
      load(0, 5'd11, 32'h0000_0B00, 4'b0000, 4'd8);
      tick();
      check("R7 port0 oldest", 64'(wr_reg[0]), 64'd9);
      check("R7 port1 next", 64'(wr_reg[1]), 64'd7);
      check("R7 both ports", 64'(wr_en), 64'h3);
      check("R7 finish pair", 64'(finish), 64'b1100);
      tick();
      check("R7 youngest next cycle", 64'(wr_reg[0]), 64'd11);
      check("R7 single port", 64'(wr_en), 64'h1);
      tick();
      check("R7 all free", 64'(busy), 64'h0);

      // R7 equal ages: lower index first
      load(1, 5'd20, 32'h0000_0001, 4'b0000, 4'd4);
      load(0, 5'd21, 32'h0000_0000, 4'b0000, 4'd4);
      tick();
      check("R7 tie lower index", 64'(wr_reg[0]), 64'd21);
      check("R7 tie second port", 64'(wr_reg[1]), 64'd20);
      tick();

      // R8 same register serialised, younger waits for shadowed older
      load(0, 5'd5, 32'h0000_0010, 4'b0001, 4'd1);
      load(1, 5'd5, 32'h0000_0020, 4'b0000, 4'd3);
      tick();
      check("R8 younger held by older", 64'(wr_en), 64'h0);
      shd_release = 4'b0001;
      tick();
      check("R8 older writes first", 64'(wr_data[0]), 64'h0000_0010);
      check("R8 single write to reg", 64'(wr_en), 64'h1);
      tick();
      check("R8 younger writes after", 64'(wr_data[0]), 64'h0000_0020);
      check("R8 younger finish", 64'(finish), 64'h2);
      tick();
      check("R8 all free", 64'(busy), 64'h0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule